// File: doc/BRIEF.md
# Twiddle Exponent Generator for a 256-Point Delay-Feedback FFT

This block produces the rotation exponent, which doubles as the coefficient ROM address, for the three non-trivial multiplier stages (stages 2, 4 and 6) of a 256-point single-path delay-feedback FFT pipeline with decimation in frequency. The odd stages only rotate by multiples of a quarter turn, so they get no exponent. Every accepted sample advances one shared 8-bit sample counter. Each multiplier stage sees that counter shifted back by its own fixed pipeline latency, so every exponent lines up with the sample that reaches that multiplier in the same cycle.

A static selection input chooses one of five equivalent decompositions. All five use the same set of multiplier resolutions: one 256-resolution multiplier, plus 64- and 16-resolution multipliers, except for one ordering that uses 16, 256 and 16. The decompositions differ in which stage gets which resolution and in the order in which coefficients are visited. That order changes how much the coefficient word toggles from one sample to the next. Each stage also reports whether it holds a valid exponent and whether a real multiplication is needed, which is the case when the exponent is not zero.

Top module: `twiddle_exp_gen`

## Requirements
- R1: While rst_ni is low, and until the first accepted strobe after reset, exp_o, vld_o and mul_o are all zero.
- R2: The sample counter starts at 0 after reset, advances by one for each cycle with valid_i high, wraps modulo 256, and holds otherwise. At strobe number t (counted from 0), stage slot j uses index c = (t - L_j) mod 256, with L_0=192 (stage 2), L_1=240 (stage 4) and L_2=252 (stage 6).
- R3: Outputs are registered. The cycle after a strobe, slot j (exp_o bits [8j+7:8j], vld_o[j], mul_o[j]) shows the result for that strobe. The cycle after a non-strobe cycle, vld_o and mul_o are 0 and exp_o holds its value.
- R4: vld_o[j] is 0 for strobes 0 to L_j-1 after reset and 1 for every strobe from number L_j on.
- R5: With case_sel_i=0, writing c[b] for bit b of c and c[h:l] for a plain binary field: slot 0 = c[5:0]*(c[7]+2c[6]) mod 256, slot 1 = c[3:0]*(c[5]+2c[4]) mod 64, slot 2 = c[1:0]*(c[3]+2c[2]) mod 16.
- R6: case_sel_i=1: slot 0 is the same as in R5, slot 1 = (2c[3]+c[2])*(c[5]+2c[4]) mod 16, slot 2 = c[1:0]*(c[5]+2c[4]+4c[3]+8c[2]) mod 64.
- R7: case_sel_i=2: slot 0 = (2c[5]+c[4])*(c[7]+2c[6]) mod 16, slot 1 = c[3:0]*(c[7]+2c[6]+4c[5]+8c[4]) mod 256, slot 2 = (2c[1]+c[0])*(c[3]+2c[2]) mod 16.
- R8: case_sel_i=3: slot 0 = c[5:2]*(c[7]+2c[6]) mod 64, slot 1 = (2c[3]+c[2])*(c[5]+2c[4]) mod 16, slot 2 = c[1:0]*(c[7]+2c[6]+4c[5]+8c[4]+16c[3]+32c[2]) mod 256.
- R9: case_sel_i=4: slot 0 = (2c[5]+c[4])*(c[7]+2c[6]) mod 16, slot 1 = (2c[3]+c[2])*(c[5]+2c[4]) mod 64, slot 2 is the same as in R8.
- R10: Each exponent is below the resolution of its slot in the selected case, so no bit at or above log2 of that resolution is ever set.
- R11: mul_o[j] is 1 exactly when vld_o[j] is 1 and the exponent on that slot is not zero.
- R12: case_sel_i stays constant while rst_ni is high. The codes 5, 6 and 7 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe; advances the sample counter |
| case_sel_i | input | 3 | Decomposition select; static outside reset |
| exp_o | output | 24 | Exponents; slot j is bits [8j+7:8j] (stages 2, 4, 6) |
| vld_o | output | 3 | Per-slot exponent valid |
| mul_o | output | 3 | Per-slot flag: non-trivial multiplication needed |

## Verification
On one strobe, the stage whose pipeline has just filled raises its valid flag for the first time while the shared counter also wraps its index field. Both the fill point and the index have to be exactly right in that cycle. The bench covers this by sweeping 512 strobes after each reset under every select code, with idle cycles mixed in. That sweep takes every stage across its fill boundary and through two full index cycles. In every cycle the valid flag, the exponent and the multiply flag are each compared against arithmetic evaluations of the field equations, as are the held values after idle cycles.

// File: rtl/twg_pkg.sv
package twg_pkg;
  localparam int IDX_W  = 8;
  localparam int SLOTS  = 3;
  localparam int CASE_W = 3;

  // field layout of one slot: k field c[kh:kl] bit-reversed, n field c[kl-1:nl]
  typedef struct packed {
    logic [2:0] kh;
    logic [2:0] kl;
    logic [2:0] nl;
    logic [3:0] res_lg;
  } fld_t;

  function automatic fld_t mk(input int kh, input int kl, input int nl, input int rl);
    fld_t f;
    f.kh = 3'(kh);
    f.kl = 3'(kl);
    f.nl = 3'(nl);
    f.res_lg = 4'(rl);
    return f;
  endfunction

  function automatic fld_t fields(input logic [CASE_W-1:0] cs, input int slot);
    fld_t f;
    unique case (cs)
      3'd1:    f = (slot == 0) ? mk(7, 6, 0, 8) : (slot == 1) ? mk(5, 4, 2, 4) : mk(5, 2, 0, 6);
      3'd2:    f = (slot == 0) ? mk(7, 6, 4, 4) : (slot == 1) ? mk(7, 4, 0, 8) : mk(3, 2, 0, 4);
      3'd3:    f = (slot == 0) ? mk(7, 6, 2, 6) : (slot == 1) ? mk(5, 4, 2, 4) : mk(7, 2, 0, 8);
      3'd4:    f = (slot == 0) ? mk(7, 6, 4, 4) : (slot == 1) ? mk(5, 4, 2, 6) : mk(7, 2, 0, 8);
      default: f = (slot == 0) ? mk(7, 6, 0, 8) : (slot == 1) ? mk(5, 4, 0, 6) : mk(3, 2, 0, 4);
    endcase
    return f;
  endfunction

  function automatic logic [IDX_W-1:0] bitrev(input logic [IDX_W-1:0] v);
    logic [IDX_W-1:0] r;
    for (int b = 0; b < IDX_W; b++) r[b] = v[IDX_W-1-b];
    return r;
  endfunction
endpackage

// File: rtl/twg_sample_ctr.sv
module twg_sample_ctr
  import twg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic [IDX_W-1:0] cnt_o
);
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/twg_exp_calc.sv
module twg_exp_calc
  import twg_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CASE_W-1:0] case_i,
  output logic [IDX_W-1:0]  exp_o
);
  fld_t               f;
  logic [3:0]         kw;
  logic [IDX_W-1:0]   kf, kr, nv, nmask, rmask;
  logic [2*IDX_W-1:0] prod;

  always_comb begin
    f     = fields(case_i, SLOT);
    kw    = 4'(f.kh) - 4'(f.kl) + 4'd1;
    kf    = idx_i >> f.kl;
    // reverse the k field so its lowest-weight digit is the top index bit
    kr    = bitrev(kf) >> (4'd8 - kw);
    nmask = 8'((9'd1 << (4'(f.kl) - 4'(f.nl))) - 9'd1);
    nv    = (idx_i >> f.nl) & nmask;
    prod  = 16'(nv) * 16'(kr);
    rmask = 8'((9'd1 << f.res_lg) - 9'd1);
    exp_o = prod[IDX_W-1:0] & rmask;
  end
endmodule

// File: rtl/twg_stage.sv
module twg_stage
  import twg_pkg::*;
#(
  parameter int SLOT = 0,
  parameter int LAT  = 192  // samples ahead of this multiplier, 0..255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IDX_W-1:0]  cnt_i,
  input  logic [CASE_W-1:0] case_i,
  output logic [IDX_W-1:0]  exp_o,
  output logic              vld_o,
  output logic              mul_o
);
  localparam logic [IDX_W-1:0] LAT_V = IDX_W'(LAT);

  logic [IDX_W-1:0] idx, exp_d, exp_q;
  logic             hit, fill_q, vld_d, vld_q, mul_q;

  assign idx = cnt_i - LAT_V;
  assign hit = (cnt_i == LAT_V);

  twg_exp_calc #(.SLOT(SLOT)) u_calc (
    .idx_i (idx),
    .case_i(case_i),
    .exp_o (exp_d)
  );

  // pipeline filled once the first sample reaches this stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              fill_q <= 1'b0;
    else if (valid_i && hit)  fill_q <= 1'b1;
  end

  assign vld_d = valid_i & (fill_q | hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      vld_q <= 1'b0;
      mul_q <= 1'b0;
    end else begin
      if (valid_i) exp_q <= exp_d;
      vld_q <= vld_d;
      mul_q <= vld_d & (|exp_d);
    end
  end

  assign exp_o = exp_q;
  assign vld_o = vld_q;
  assign mul_o = mul_q;
endmodule

// File: rtl/twiddle_exp_gen.sv
module twiddle_exp_gen
  import twg_pkg::*;
#(
  parameter int LAT_S2 = 192,
  parameter int LAT_S4 = 240,
  parameter int LAT_S6 = 252
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [CASE_W-1:0]       case_sel_i,
  output logic [SLOTS*IDX_W-1:0]  exp_o,
  output logic [SLOTS-1:0]        vld_o,
  output logic [SLOTS-1:0]        mul_o
);
  localparam int LAT_A [SLOTS] = '{LAT_S2, LAT_S4, LAT_S6};

  logic [IDX_W-1:0] cnt;

  twg_sample_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .cnt_o  (cnt)
  );

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    twg_stage #(.SLOT(j), .LAT(LAT_A[j])) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(valid_i),
      .cnt_i  (cnt),
      .case_i (case_sel_i),
      .exp_o  (exp_o[IDX_W*j +: IDX_W]),
      .vld_o  (vld_o[j]),
      .mul_o  (mul_o[j])
    );
  end
endmodule

// File: rtl/twiddle_exp_gen_chk.sv
module twiddle_exp_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [2:0]  case_sel_i,
  input logic [23:0] exp_o,
  input logic [2:0]  vld_o,
  input logic [2:0]  mul_o
);
  function automatic logic [7:0] lim(input logic [2:0] cs, input int s);
    int r;
    case (cs)
      3'd1:    r = (s == 0) ? 256 : (s == 1) ? 16  : 64;
      3'd2:    r = (s == 0) ? 16  : (s == 1) ? 256 : 16;
      3'd3:    r = (s == 0) ? 64  : (s == 1) ? 16  : 256;
      3'd4:    r = (s == 0) ? 16  : (s == 1) ? 64  : 256;
      default: r = (s == 0) ? 256 : (s == 1) ? 64  : 16;
    endcase
    return 8'(r - 1);
  endfunction

  AST_CASE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(case_sel_i)); // R12

  AST_VLD_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|vld_o) |-> $past(valid_i)); // R3

  AST_EXP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(exp_o)); // R3

  AST_FILL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o[2] |-> (vld_o[1] && vld_o[0])); // R4

  for (genvar j = 0; j < 3; j++) begin : g_chk
    AST_RES_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exp_o[8*j +: 8] & ~lim(case_sel_i, j)) == 8'd0); // R10

    AST_MUL_NONTRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mul_o[j] |-> (vld_o[j] && exp_o[8*j +: 8] != 8'd0)); // R11

    AST_MUL_WHEN_NEEDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_o[j] && exp_o[8*j +: 8] != 8'd0) |-> mul_o[j]); // R11
  end
endmodule

bind twiddle_exp_gen twiddle_exp_gen_chk u_chk (.*);

// File: tb/twiddle_exp_gen_bench.sv
module twiddle_exp_gen_bench;
  localparam int NSTROBE = 512;
  localparam int LAT [3] = '{192, 240, 252};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  case_sel_i = 3'd0;
  logic [23:0] exp_o;
  logic [2:0]  vld_o, mul_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  twiddle_exp_gen u_twiddle_exp_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .case_sel_i(case_sel_i),
    .exp_o(exp_o), .vld_o(vld_o), .mul_o(mul_o)
  );

  function automatic int bt(input int c, input int i);
    return (c >> i) & 1;
  endfunction

  // independent evaluation of the index equations per select code
  function automatic int model(input int cs, input int s, input int c);
    int ka, kb, k4, k6;
    ka = bt(c,7) + 2*bt(c,6);
    kb = bt(c,5) + 2*bt(c,4);
    k4 = bt(c,7) + 2*bt(c,6) + 4*bt(c,5) + 8*bt(c,4);
    k6 = k4 + 16*bt(c,3) + 32*bt(c,2);
    case (cs)
      1: case (s)
           0: return ((c % 64) * ka) % 256;
           1: return ((2*bt(c,3) + bt(c,2)) * kb) % 16;
           default: return ((c % 4) * (bt(c,5) + 2*bt(c,4) + 4*bt(c,3) + 8*bt(c,2))) % 64;
         endcase
      2: case (s)
           0: return ((2*bt(c,5) + bt(c,4)) * ka) % 16;
           1: return ((c % 16) * k4) % 256;
           default: return ((2*bt(c,1) + bt(c,0)) * (bt(c,3) + 2*bt(c,2))) % 16;
         endcase
      3: case (s)
           0: return (((c / 4) % 16) * ka) % 64;
           1: return ((2*bt(c,3) + bt(c,2)) * kb) % 16;
           default: return ((c % 4) * k6) % 256;
         endcase
      4: case (s)
           0: return ((2*bt(c,5) + bt(c,4)) * ka) % 16;
           1: return ((2*bt(c,3) + bt(c,2)) * kb) % 64;
           default: return ((c % 4) * k6) % 256;
         endcase
      default: case (s)
           0: return ((c % 64) * ka) % 256;
           1: return ((c % 16) * kb) % 64;
           default: return ((c % 4) * (bt(c,3) + 2*bt(c,2))) % 16;
         endcase
    endcase
  endfunction

  function automatic int res_of(input int cs, input int s);
    case (cs)
      1: return (s == 0) ? 256 : (s == 1) ? 16  : 64;
      2: return (s == 0) ? 16  : (s == 1) ? 256 : 16;
      3: return (s == 0) ? 64  : (s == 1) ? 16  : 256;
      4: return (s == 0) ? 16  : (s == 1) ? 64  : 256;
      default: return (s == 0) ? 256 : (s == 1) ? 64 : 16;
    endcase
  endfunction

  function automatic string case_tag(input int cs);
    case (cs)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic run_case(input int cs);
    bit pv = 1'b0;
    bit started = 1'b0;
    int pt = 0;
    int t = 0;
    int cyc = 0;
    int hold [3] = '{0, 0, 0};
    rst_ni = 1'b0;
    valid_i = 1'b0;
    case_sel_i = 3'(cs);
    repeat (2) @(negedge clk_i);
    chk("R1 exp in reset", int'(exp_o), 0);
    chk("R1 vld in reset", int'(vld_o), 0);
    rst_ni = 1'b1;
    #1;
    chk("R1 mul after release", int'(mul_o), 0);
    @(negedge clk_i);
    while (t < NSTROBE || pv) begin
      if (started) begin
        for (int j = 0; j < 3; j++) begin
          int ea = int'(exp_o[8*j +: 8]);
          if (pv) begin
            int idx = (pt + 512 - LAT[j]) % 256;
            int ee = model(cs, j, idx);
            int ve = (pt >= LAT[j]) ? 1 : 0;
            hold[j] = ee;
            chk({"R2/", case_tag(cs), " exponent"}, ea, ee);
            chk("R4 stage valid", int'(vld_o[j]), ve);
            chk("R11 multiply flag", int'(mul_o[j]), (ve == 1 && ee != 0) ? 1 : 0);
            chk("R10 below resolution", (ea < res_of(cs, j)) ? 1 : 0, 1);
          end else begin
            chk("R3 exponent held", ea, hold[j]);
            chk("R3 vld idle", int'(vld_o[j]), 0);
            chk("R3 mul idle", int'(mul_o[j]), 0);
          end
        end
      end
      started = 1'b1;
      if (t < NSTROBE && (cyc % 7) != 3) begin
        valid_i = 1'b1;
        pv = 1'b1;
        pt = t;
        t++;
      end else begin
        valid_i = 1'b0;
        pv = 1'b0;
      end
      cyc++;
      @(negedge clk_i);
    end
    valid_i = 1'b0;
  endtask

  initial begin
    for (int cs = 0; cs < 8; cs++) run_case(cs);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 final reset", int'(vld_o) + int'(mul_o) + int'(exp_o), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule